// File: doc/BRIEF.md
# Calendar alarm comparator

This block watches a running calendar and raises an alarm when the time reaches a programmed moment. It holds six alarm fields: seconds, minutes, hours, weekday, day of month and month. Each field is a byte that holds a two-digit BCD value and a compare-enable bit. A field with its enable clear matches any time. A calendar counter elsewhere in the chip supplies the current BCD time and a one-cycle pulse each time that time changes.

The match is checked only on that update pulse. The alarm flag sets on the first update at which at least one field is enabled and every enabled field equals the time. The flag stays set until software clears it. The alarm interrupt is the flag gated by an enable bit in a control byte. Software reaches the six alarm bytes and the control byte through a simple write/read port. The read data is combinational from the address.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, every alarm field and the control byte read 0x00 and `alarm_irq` is low.
- R2: Addresses 0 to 5 select seconds, minutes, hours, weekday, day of month and month, in that order. A write stores the full byte and a read returns it unchanged.
- R3: In each alarm byte, bit 7 is the compare enable and bits 6:0 are the BCD value. A field with bit 7 at 0 matches any time value, so writing 0x00 makes the field don't-care.
- R4: The alarm flag sets at the clock edge where `time_tick` is high, at least one field is enabled, and every enabled field's bits 6:0 equal the matching 7-bit slice of `now_bcd`. A match without `time_tick` sets nothing.
- R5: When no field is enabled, the flag never sets.
- R6: A tick whose match continues an unbroken match from the previous tick does not set the flag again. Any write to an alarm field clears this memory, so the next matching tick sets the flag.
- R7: The control byte is at address 6, with the alarm flag in bit 0 and the interrupt enable in bit 3. Its other bits read 0. Writing 0 to bit 0 clears the flag and writing 1 leaves it unchanged. A set and a clear in the same cycle leave the flag set. Bit 3 takes the written value.
- R8: `alarm_irq` is high exactly when both the flag and the interrupt enable are set.
- R9: A mismatch in any single enabled field blocks the alarm, even when every other enabled field matches.
- R10: Address 7 reads 0x00, and a write to it changes no alarm field and no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_tick | input | 1 | One-cycle pulse when the calendar time has updated |
| now_bcd | input | 42 | Current time: six 7-bit BCD slices, seconds in bits 6:0 up to month in bits 41:35 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0-5 alarm fields, 6 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
A corrupted alarm byte shows on `reg_rdata` in the same cycle its address is read. It also shows as a missing or extra flag at the next matching tick. A wrong continuation memory behaves differently: a persistent match then sets the flag again after software clears it, or a new alarm fails to set it. Neither shows at the ports until a second tick arrives inside the same match. The reference model therefore reads the control byte on every cycle and holds matches across several ticks.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int REG_W    = 8;
  localparam int BCD_W    = 7;
  localparam int EN_BIT   = 7;
  localparam int FLAG_BIT = 0;
  localparam int IE_BIT   = 3;

  // R3: enable lives in the top bit of every alarm byte
  function automatic logic field_enabled(input logic [REG_W-1:0] r);
    return r[EN_BIT];
  endfunction

  // R3: a disabled field is a wildcard, an enabled one needs equality
  function automatic logic field_hit(input logic [REG_W-1:0] r,
                                     input logic [BCD_W-1:0] now);
    return !r[EN_BIT] || (r[BCD_W-1:0] == now);
  endfunction

  function automatic logic [REG_W-1:0] ctrl_byte(input logic flag,
                                                 input logic ie);
    logic [REG_W-1:0] b;
    b           = '0;
    b[FLAG_BIT] = flag;
    b[IE_BIT]   = ie;
    return b;
  endfunction
endpackage

// File: rtl/alarm_field_bank.sv
module alarm_field_bank
  import cal_alarm_pkg::*;
#(
  parameter int NUM_FIELDS = 6,
  parameter int ADDR_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [NUM_FIELDS*REG_W-1:0] fields_flat,
  output logic                        field_written
);
  logic [NUM_FIELDS-1:0] wr_sel;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [REG_W-1:0] field_q;
    assign wr_sel[g] = reg_wr && (reg_addr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)         field_q <= '0;
      else if (wr_sel[g]) field_q <= reg_wdata;
    end
    assign fields_flat[g*REG_W +: REG_W] = field_q;
  end

  assign field_written = |wr_sel;
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import cal_alarm_pkg::*;
#(
  parameter int NUM_FIELDS = 6
) (
  input  logic [NUM_FIELDS*REG_W-1:0] fields_flat,
  input  logic [NUM_FIELDS*BCD_W-1:0] now_bcd,
  output logic                        any_en,
  output logic                        all_hit
);
  logic [NUM_FIELDS-1:0] en_vec;
  logic [NUM_FIELDS-1:0] hit_vec;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    assign en_vec[g]  = field_enabled(fields_flat[g*REG_W +: REG_W]);
    assign hit_vec[g] = field_hit(fields_flat[g*REG_W +: REG_W],
                                  now_bcd[g*BCD_W +: BCD_W]);
  end

  assign any_en  = |en_vec;
  assign all_hit = &hit_vec;
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
  import cal_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             time_tick,
  input  logic             any_en,
  input  logic             all_hit,
  input  logic             field_written,
  input  logic             ctrl_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             flag_q,
  output logic             ie_q,
  output logic             prev_hit,
  output logic             set_ev
);
  logic match_now;
  logic ctrl_clr;

  assign match_now = any_en && all_hit;
  // R6: fire only on entry into a match
  assign set_ev    = time_tick && match_now && !prev_hit;
  assign ctrl_clr  = ctrl_wr && !reg_wdata[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      ie_q     <= 1'b0;
      prev_hit <= 1'b0;
    end else begin
      // R7: hardware set has priority over a software clear
      if (set_ev)        flag_q <= 1'b1;
      else if (ctrl_clr) flag_q <= 1'b0;
      if (ctrl_wr)       ie_q   <= reg_wdata[IE_BIT];
      if (field_written) prev_hit <= 1'b0;
      else if (time_tick) prev_hit <= match_now;
    end
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int NUM_FIELDS = 6,
  parameter int ADDR_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        time_tick,
  input  logic [NUM_FIELDS*BCD_W-1:0] now_bcd,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  output logic                        alarm_irq
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS);

  logic [NUM_FIELDS*REG_W-1:0] fields_flat;
  logic field_written;
  logic any_en, all_hit;
  logic flag_q, ie_q, prev_hit, set_ev;
  logic ctrl_wr;

  assign ctrl_wr = reg_wr && (reg_addr == CTRL_ADDR);

  alarm_field_bank #(.NUM_FIELDS(NUM_FIELDS), .ADDR_W(ADDR_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fields_flat(fields_flat),
    .field_written(field_written)
  );

  alarm_match_unit #(.NUM_FIELDS(NUM_FIELDS)) match_i (
    .fields_flat(fields_flat), .now_bcd(now_bcd),
    .any_en(any_en), .all_hit(all_hit)
  );

  alarm_flag_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .time_tick(time_tick), .any_en(any_en),
    .all_hit(all_hit), .field_written(field_written), .ctrl_wr(ctrl_wr),
    .reg_wdata(reg_wdata), .flag_q(flag_q), .ie_q(ie_q),
    .prev_hit(prev_hit), .set_ev(set_ev)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = fields_flat[i*REG_W +: REG_W];
    if (reg_addr == CTRL_ADDR) reg_rdata = ctrl_byte(flag_q, ie_q);
  end

  assign alarm_irq = flag_q && ie_q;
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
  import cal_alarm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             time_tick,
  input logic             ctrl_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic             flag_q,
  input logic             ie_q,
  input logic             prev_hit,
  input logic             any_en,
  input logic             alarm_irq
);
  // R4
  flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(time_tick));

  // R5
  no_enable_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_tick && !any_en && !flag_q) |=> !flag_q);

  // R6
  no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_tick && prev_hit && !flag_q) |=> !flag_q);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(ctrl_wr && !reg_wdata[FLAG_BIT])) |=> flag_q);

  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> (ie_q && flag_q));
endmodule

bind cal_alarm_match cal_alarm_chk chk_i (
  .clk(clk), .rst_n(rst_n), .time_tick(time_tick), .ctrl_wr(ctrl_wr),
  .reg_wdata(reg_wdata), .flag_q(flag_q), .ie_q(ie_q),
  .prev_hit(prev_hit), .any_en(any_en), .alarm_irq(alarm_irq)
);

// File: tb/cal_alarm_match_tb_top.sv
`timescale 1ns/1ps
module cal_alarm_match_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        time_tick = 1'b0;
  logic [41:0] now_bcd = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        alarm_irq;

  always #2 clk = ~clk;

  cal_alarm_match dut_i (
    .clk(clk), .rst_n(rst_n), .time_tick(time_tick), .now_bcd(now_bcd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // behavioural reference
  int m_alarm[6];
  int m_time[6];
  int m_flag, m_ie, m_cont;

  function automatic int exp_read(int a);
    if (a < 6)  return m_alarm[a];
    if (a == 6) return m_flag + 8 * m_ie;
    return 0;
  endfunction

  function automatic int model_match();
    int en = 0;
    int ok = 1;
    for (int i = 0; i < 6; i++)
      if (m_alarm[i] >= 128) begin
        en++;
        if ((m_alarm[i] % 128) != m_time[i]) ok = 0;
      end
    return (en > 0 && ok == 1) ? 1 : 0;
  endfunction

  task automatic step(input bit wr, input int a, input int wd, input bit tk,
                      input string tag);
    int h;
    @(negedge clk);
    reg_wr = wr; reg_addr = 3'(a); reg_wdata = 8'(wd); time_tick = tk;
    for (int i = 0; i < 6; i++) now_bcd[i*7 +: 7] = 7'(m_time[i]);
    #1;
    vectors++;
    if (reg_rdata !== 8'(exp_read(a))) begin
      fails++;
      $display("FAIL %s: rdata addr %0d got %02h expected %02h", tag, a,
               reg_rdata, exp_read(a));
    end
    vectors++;
    if (alarm_irq !== ((m_flag & m_ie) == 1)) begin
      fails++;
      $display("FAIL R8 (%s): irq got %0b expected %0d", tag, alarm_irq,
               m_flag & m_ie);
    end
    @(posedge clk);
    h = model_match();
    if (tk && h == 1 && m_cont == 0) m_flag = 1;
    else if (wr && a == 6 && (wd % 2) == 0) m_flag = 0;
    if (wr && a == 6) m_ie = (wd / 8) % 2;
    if (wr && a < 6) begin m_alarm[a] = wd; m_cont = 0; end
    else if (tk) m_cont = h;
  endtask

  task automatic wr_reg(input int a, input int v, input string tag);
    step(1, a, v, 0, tag);
  endtask
  task automatic rd_reg(input int a, input string tag);
    step(0, a, 0, 0, tag);
  endtask
  task automatic tick_at(input int f, input int v, input string tag);
    m_time[f] = v;
    step(0, 6, 0, 1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin m_alarm[i] = 0; m_time[i] = 0; end
    m_flag = 0; m_ie = 0; m_cont = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state, R10 unused address
    for (int a = 0; a < 8; a++) rd_reg(a, "R1");
    // R2 readback of full bytes, R3 field layout
    wr_reg(0, 8'hff, "R2"); wr_reg(1, 8'h00, "R2"); wr_reg(2, 8'ha3, "R2");
    wr_reg(3, 8'h06, "R3"); wr_reg(4, 8'h80, "R3"); wr_reg(5, 8'h12, "R2");
    for (int a = 0; a < 6; a++) rd_reg(a, "R2");
    // R10 write to address 7 ignored
    wr_reg(7, 8'hff, "R10");
    for (int a = 0; a < 8; a++) rd_reg(a, "R10");

    // seconds-only alarm
    for (int a = 0; a < 6; a++) wr_reg(a, 0, "R3");
    wr_reg(0, 8'hb0, "R3");
    m_time[0] = 7'h30; step(0, 6, 0, 0, "R4"); rd_reg(6, "R4");
    tick_at(0, 7'h29, "R4"); rd_reg(6, "R4");
    tick_at(0, 7'h30, "R4"); rd_reg(6, "R4");
    wr_reg(6, 8'h09, "R7"); rd_reg(6, "R8");
    wr_reg(6, 8'h08, "R7"); rd_reg(6, "R7");

    // two enabled fields, one mismatched
    wr_reg(0, 0, "R9"); wr_reg(1, 8'h95, "R9"); wr_reg(2, 8'h87, "R9");
    m_time[2] = 7'h08; tick_at(1, 7'h15, "R9"); rd_reg(6, "R9");
    tick_at(2, 7'h07, "R9"); rd_reg(6, "R9");

    // persistent month match fires once
    wr_reg(6, 8'h08, "R6");
    for (int a = 0; a < 5; a++) wr_reg(a, 0, "R6");
    wr_reg(5, 8'h92, "R6");
    tick_at(5, 7'h12, "R6"); rd_reg(6, "R6");
    wr_reg(6, 8'h08, "R6");
    tick_at(5, 7'h12, "R6"); tick_at(5, 7'h12, "R6"); rd_reg(6, "R6");
    tick_at(5, 7'h01, "R6"); tick_at(5, 7'h12, "R6"); rd_reg(6, "R6");
    wr_reg(6, 8'h08, "R6"); wr_reg(5, 8'h92, "R6");
    tick_at(5, 7'h12, "R6"); rd_reg(6, "R6");

    // set and clear in the same cycle
    wr_reg(6, 8'h08, "R7"); wr_reg(5, 8'h92, "R7");
    m_time[5] = 7'h12; step(1, 6, 8'h08, 1, "R7"); rd_reg(6, "R7");

    // nothing enabled
    wr_reg(6, 8'h00, "R5");
    for (int a = 0; a < 6; a++) wr_reg(a, 8'h00, "R5");
    for (int i = 0; i < 6; i++) m_time[i] = 0;
    for (int k = 0; k < 4; k++) step(0, 6, 0, 1, "R5");

    // mixed random traffic
    for (int k = 0; k < 600; k++) begin
      int pick;
      pick = int'($urandom_range(0, 9));
      for (int i = 0; i < 6; i++)
        if ($urandom_range(0, 3) == 0) m_time[i] = int'($urandom_range(0, 2)) * 16 + 1;
      if (pick == 0)
        step(1, int'($urandom_range(0, 5)),
             int'($urandom_range(0, 1)) * 128 + int'($urandom_range(0, 2)) * 16 + 1,
             $urandom_range(0, 1) == 1, "R4");
      else if (pick == 1)
        step(1, 6, int'($urandom_range(0, 255)), $urandom_range(0, 1) == 1, "R7");
      else
        step(0, int'($urandom_range(0, 7)), 0, $urandom_range(0, 1) == 1, "R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule